// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation that missed in a translation cache. It takes a 14-bit virtual address and the physical base address of a page directory. It then fetches two entries from memory, one after the other: first the directory entry, then the leaf entry. The result is either a physical frame number and the full physical address, or a fault that says which level was invalid. Pages are 64 bytes, and every entry is a 32-bit word. A directory page and a leaf page each hold 16 entries.

The surrounding logic raises `start_i` for one cycle. It then waits for a one-cycle `done_o` or `fault_o` pulse and uses `frame_o` and `paddr_o` to refill its cache. Memory is reached through a request channel with a valid/ready handshake, followed by a response with a valid strobe. Only one read is outstanding at a time.

Top module: `ptw_walker`

## Requirements
- R1: The virtual address is split into three fields. Bits [13:10] are the directory index, bits [9:6] are the leaf index, and bits [5:0] are the byte offset.
- R2: The first read goes to `dir_base_i + 4*dir_index`, taken modulo 2^14. Both `dir_base_i` and the directory index are captured in the cycle the walk is accepted.
- R3: A directory entry whose bit 0 is clear ends the walk with `fault_o` and `fault_lvl_o`=0. No second read is issued.
- R4: The second read goes to `64*F + 4*leaf_index`, where F is bits [15:8] of the directory entry.
- R5: A leaf entry whose bit 0 is clear ends the walk with `fault_o` and `fault_lvl_o`=1, after exactly two reads.
- R6: A leaf entry whose bit 0 is set ends the walk with `done_o` after exactly two reads. On that pulse, `frame_o` equals bits [15:8] of the leaf entry and `paddr_o` equals `{frame_o, offset}`. Entry bits other than 0 and [15:8] have no effect.
- R7: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays asserted and its address does not change.
- R8: After a request is accepted, no further request is made until its response has arrived.
- R9: `busy_o` is high from the cycle after acceptance until the cycle after the done or fault pulse. A `start_i` that arrives while `busy_o` is high is ignored: it changes neither the result nor the reads, and it does not queue a walk.
- R10: `done_o` and `fault_o` are never high together, and each lasts exactly one cycle.
- R11: A response strobe that arrives while no read is outstanding is ignored.
- R12: After reset, `busy_o`, `mem_req_valid_o`, `done_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (only accepted when idle) |
| vaddr_i | input | 14 | Virtual address to translate |
| dir_base_i | input | 14 | Physical byte address of the page directory |
| busy_o | output | 1 | Walk in progress |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 14 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry read from memory |
| done_o | output | 1 | One-cycle pulse, translation found |
| fault_o | output | 1 | One-cycle pulse, invalid entry met |
| fault_lvl_o | output | 1 | 0 for the directory level, 1 for the leaf level |
| frame_o | output | 8 | Physical frame number of the last successful walk |
| paddr_o | output | 14 | Frame number joined to the page offset |

## Verification
The embedded properties cover the handshake and pulse rules on every cycle. They check that a stalled request holds, that no request follows an accepted one, and that the done and fault pulses are exclusive and one cycle long. They also check that every outcome matches the entry on the response bus in the previous cycle, and that the latched address does not move while busy.

Some behaviour only the bench scenarios can show. This covers the exact address of each read, including wraparound of the directory base, and the count of reads for each kind of outcome. It also covers the full physical address, and that stray responses and late starts leave the result and the read sequence untouched.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENT_SZ_LOG = 2;   // 4-byte entries
  localparam int VLD_BIT    = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_PDE,
    ST_WAIT_PDE,
    ST_RD_PTE,
    ST_WAIT_PTE,
    ST_DONE,
    ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int DIR_W = 4,
  parameter int TBL_W = 4,
  parameter int FRM_W = 8,
  parameter int PA_W  = 14
) (
  input  logic             sel_leaf_i,
  input  logic [PA_W-1:0]  dir_base_i,
  input  logic [DIR_W-1:0] dir_idx_i,
  input  logic [TBL_W-1:0] tbl_idx_i,
  input  logic [FRM_W-1:0] pde_frame_i,
  output logic [PA_W-1:0]  addr_o
);
  import ptw_pkg::*;

  localparam int DOFF_W = DIR_W + ENT_SZ_LOG;

  logic [PA_W-1:0] dir_off;
  logic [PA_W-1:0] pde_addr;
  logic [PA_W-1:0] pte_addr;

  always_comb begin
    dir_off = '0;
    dir_off[DOFF_W-1:0] = {dir_idx_i, {ENT_SZ_LOG{1'b0}}};
  end

  assign pde_addr = dir_base_i + dir_off;  // wraps modulo 2^PA_W
  assign pte_addr = {pde_frame_i, tbl_idx_i, {ENT_SZ_LOG{1'b0}}};
  assign addr_o   = sel_leaf_i ? pte_addr : pde_addr;
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  req_ready_i,
  input  logic                  rsp_valid_i,
  input  logic                  rsp_ok_i,
  output ptw_pkg::walk_state_e  state_o,
  output logic                  accept_o,
  output logic                  pde_ld_o,
  output logic                  pte_ld_o
);
  import ptw_pkg::*;

  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_RD_PDE;
      ST_RD_PDE:   if (req_ready_i) state_d = ST_WAIT_PDE;
      ST_WAIT_PDE: if (rsp_valid_i) state_d = rsp_ok_i ? ST_RD_PTE : ST_FAULT;
      ST_RD_PTE:   if (req_ready_i) state_d = ST_WAIT_PTE;
      ST_WAIT_PTE: if (rsp_valid_i) state_d = rsp_ok_i ? ST_DONE : ST_FAULT;
      ST_DONE:     state_d = ST_IDLE;
      ST_FAULT:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign pde_ld_o = (state_q == ST_WAIT_PDE) && rsp_valid_i;
  assign pte_ld_o = (state_q == ST_WAIT_PTE) && rsp_valid_i;

  // R8
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RD_PDE || state_q == ST_RD_PTE) && req_ready_i)
      |=> !(state_q == ST_RD_PDE || state_q == ST_RD_PTE));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int DIR_W   = 4,
  parameter int TBL_W   = 4,
  parameter int FRM_W   = 8,
  parameter int ENT_W   = 32,
  parameter int FRM_LSB = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [DIR_W+2*TBL_W+1:0]    vaddr_i,
  input  logic [FRM_W+TBL_W+1:0]      dir_base_i,
  output logic                        busy_o,
  output logic                        mem_req_valid_o,
  input  logic                        mem_req_ready_i,
  output logic [FRM_W+TBL_W+1:0]      mem_req_addr_o,
  input  logic                        mem_rsp_valid_i,
  input  logic [ENT_W-1:0]            mem_rsp_data_i,
  output logic                        done_o,
  output logic                        fault_o,
  output logic                        fault_lvl_o,
  output logic [FRM_W-1:0]            frame_o,
  output logic [FRM_W+TBL_W+1:0]      paddr_o
);
  import ptw_pkg::*;

  localparam int OFF_W = TBL_W + ENT_SZ_LOG;
  localparam int VA_W  = DIR_W + TBL_W + OFF_W;
  localparam int PA_W  = FRM_W + OFF_W;

  walk_state_e       state;
  logic              accept, pde_ld, pte_ld, rsp_ok;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   base_q;
  logic [FRM_W-1:0]  pde_frm_q, frame_q;
  logic              lvl_q;
  logic [FRM_W-1:0]  rsp_frame;

  assign rsp_ok    = mem_rsp_data_i[VLD_BIT];
  assign rsp_frame = mem_rsp_data_i[FRM_LSB +: FRM_W];

  logic unused_rsp_bits;
  assign unused_rsp_bits = ^{mem_rsp_data_i[ENT_W-1:FRM_LSB+FRM_W],
                             mem_rsp_data_i[FRM_LSB-1:VLD_BIT+1]};

  ptw_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .req_ready_i (mem_req_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_ok_i    (rsp_ok),
    .state_o     (state),
    .accept_o    (accept),
    .pde_ld_o    (pde_ld),
    .pte_ld_o    (pte_ld)
  );

  ptw_addr_gen #(
    .DIR_W (DIR_W),
    .TBL_W (TBL_W),
    .FRM_W (FRM_W),
    .PA_W  (PA_W)
  ) u_addr (
    .sel_leaf_i  (state == ST_RD_PTE),
    .dir_base_i  (base_q),
    .dir_idx_i   (va_q[VA_W-1 -: DIR_W]),
    .tbl_idx_i   (va_q[OFF_W +: TBL_W]),
    .pde_frame_i (pde_frm_q),
    .addr_o      (mem_req_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q      <= '0;
      base_q    <= '0;
      pde_frm_q <= '0;
      frame_q   <= '0;
      lvl_q     <= 1'b0;
    end else begin
      if (accept) begin
        va_q   <= vaddr_i;
        base_q <= dir_base_i;
      end
      if (pde_ld) begin
        pde_frm_q <= rsp_frame;
        if (!rsp_ok) lvl_q <= 1'b0;
      end
      if (pte_ld) begin
        if (rsp_ok) frame_q <= rsp_frame;
        else        lvl_q   <= 1'b1;
      end
    end
  end

  assign busy_o          = (state != ST_IDLE);
  assign mem_req_valid_o = (state == ST_RD_PDE) || (state == ST_RD_PTE);
  assign done_o          = (state == ST_DONE);
  assign fault_o         = (state == ST_FAULT);
  assign fault_lvl_o     = lvl_q;
  assign frame_o         = frame_q;
  assign paddr_o         = {frame_q, va_q[OFF_W-1:0]};

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R10
  done_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  fault_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);

  // R9
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(va_q));

  // R3
  dir_fault_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_lvl_o) |-> ($past(mem_rsp_valid_i) && !$past(mem_rsp_data_i[VLD_BIT])));

  // R6
  done_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(mem_rsp_valid_i) && $past(mem_rsp_data_i[VLD_BIT])
                && frame_o == $past(mem_rsp_data_i[FRM_LSB +: FRM_W])));
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [13:0] vaddr = '0;
  logic [13:0] dbase = '0;
  logic        req_ready = 1'b0;
  logic        rsp_v = 1'b0;
  logic [31:0] rsp_d = '0;
  logic        busy, req_valid, done, fault, flvl;
  logic [13:0] req_addr, paddr;
  logic [7:0]  frame;

  always #4 clk = ~clk;  // 125 MHz

  ptw_walker u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .start_i         (start),
    .vaddr_i         (vaddr),
    .dir_base_i      (dbase),
    .busy_o          (busy),
    .mem_req_valid_o (req_valid),
    .mem_req_ready_i (req_ready),
    .mem_req_addr_o  (req_addr),
    .mem_rsp_valid_i (rsp_v),
    .mem_rsp_data_i  (rsp_d),
    .done_o          (done),
    .fault_o         (fault),
    .fault_lvl_o     (flvl),
    .frame_o         (frame),
    .paddr_o         (paddr)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mem [int];
  logic [13:0] exp_addr [$];
  string       exp_tag  [$];
  int  stall_cfg = 0;
  int  lat_cfg   = 0;
  bit  stray_cfg = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [13:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
  endfunction

  // entry: bit 0 valid, [15:8] frame; other bits filled with noise
  function automatic logic [31:0] ent(input logic [7:0] f, input bit v);
    return {16'hA5C3, f, 7'h5A, v};
  endfunction

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      rsp_v = 1'b0;
      req_ready = 1'b0;
      if (req_valid) begin
        logic [13:0] a0;
        a0 = req_addr;
        for (int s = 0; s < stall_cfg; s++) begin
          if (stray_cfg) begin rsp_v = 1'b1; rsp_d = 32'h0000_FF01; end
          @(negedge clk);
          rsp_v = 1'b0;
          chk(req_valid && req_addr == a0, "R7", "request held during stall", req_addr, a0);
        end
        req_ready = 1'b1;
        if (exp_addr.size() == 0) begin
          chk(1'b0, "R8", "unexpected read request", req_addr, 0);
        end else begin
          logic [13:0] ea;
          string tg;
          ea = exp_addr.pop_front();
          tg = exp_tag.pop_front();
          chk(req_addr == ea, tg, "read address", req_addr, ea);
        end
        @(negedge clk);
        req_ready = 1'b0;
        repeat (lat_cfg) begin
          @(negedge clk);
          chk(!req_valid, "R8", "no request while read outstanding", req_valid, 0);
        end
        rsp_v = 1'b1;
        rsp_d = rd(a0);
        @(negedge clk);
        rsp_v = 1'b0;
      end else if (stray_cfg && !busy) begin
        rsp_v = 1'b1;
        rsp_d = 32'h0000_AB01;
      end
    end
  end

  task automatic run_walk(input logic [13:0] va, input logic [13:0] base,
                          input int stall, input int lat, input bit stray,
                          input bit late_start, input string req);
    logic [13:0] pde_a, pte_a;
    logic [31:0] pde, pte;
    bit exp_fault, exp_lvl;
    logic [7:0] exp_frm;
    int cyc;
    pde_a = base + {8'h0, va[13:10], 2'b00};
    pde = rd(pde_a);
    exp_addr.push_back(pde_a); exp_tag.push_back("R2");
    exp_frm = '0; exp_lvl = 1'b0;
    if (!pde[0]) begin
      exp_fault = 1'b1;
    end else begin
      pte_a = {pde[15:8], va[9:6], 2'b00};
      pte = rd(pte_a);
      exp_addr.push_back(pte_a); exp_tag.push_back("R4");
      exp_fault = !pte[0];
      exp_lvl = 1'b1;
      exp_frm = pte[15:8];
    end
    stall_cfg = stall; lat_cfg = lat; stray_cfg = stray;
    @(negedge clk);
    start = 1'b1; vaddr = va; dbase = base;
    @(negedge clk);
    start = 1'b0; vaddr = ~va; dbase = ~base;
    chk(busy, "R9", "busy after accept", busy, 1);
    if (late_start) begin
      start = 1'b1; vaddr = 14'h3FFF; dbase = 14'h0100;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!(done || fault) && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 400) begin
      chk(1'b0, req, "walk timed out", cyc, 0);
      return;
    end
    chk(!(done && fault), "R10", "done and fault exclusive", {done, fault}, 0);
    if (exp_fault) begin
      chk(fault, req, "fault outcome", fault, 1);
      chk(flvl == exp_lvl, req, "fault level", flvl, exp_lvl);
    end else begin
      chk(done, req, "done outcome", done, 1);
      chk(frame == exp_frm, "R6", "frame", frame, exp_frm);
      chk(paddr == {exp_frm, va[5:0]}, "R1", "physical address", paddr, {exp_frm, va[5:0]});
    end
    if (late_start) start = 1'b1;  // arrives in the pulse cycle, still busy
    @(negedge clk);
    start = 1'b0;
    chk(!done && !fault, "R10", "pulse lasts one cycle", {done, fault}, 0);
    chk(!busy, "R9", "idle after pulse", busy, 0);
    chk(exp_addr.size() == 0, req, "reads remaining", exp_addr.size(), 0);
    repeat (4) begin
      @(negedge clk);
      chk(!busy && !req_valid, "R9", "no queued walk", {busy, req_valid}, 0);
    end
    stray_cfg = 1'b0;
    exp_addr.delete();
    exp_tag.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !req_valid && !done && !fault, "R12", "reset state",
        {busy, req_valid, done, fault}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req_valid, "R12", "idle after reset", {busy, req_valid}, 0);

    // directory at 0x0400
    mem[14'h040C] = ent(8'h21, 1'b1);            // dir 3 -> frame 0x21
    mem[14'h0854] = ent(8'h7E, 1'b1);            // leaf 5
    mem[14'h0858] = ent(8'h33, 1'b0);            // leaf 6 invalid
    mem[14'h0424] = ent(8'h44, 1'b0);            // dir 9 invalid
    mem[14'h043C] = ent(8'hFF, 1'b1);            // dir 15 -> frame 0xFF
    mem[14'h3FFC] = ent(8'hFF, 1'b1);            // leaf 15 of frame 0xFF
    // wrapped directory base 0x3FF0, dir 15 -> 0x002C
    mem[14'h002C] = ent(8'h10, 1'b1);
    mem[14'h0400 + 14'h0] = ent(8'h02, 1'b1);    // dir 0 -> frame 0x02
    mem[14'h0080] = ent(8'h9C, 1'b1);            // leaf 0 of frame 0x02 / frame 0x10? distinct below
    mem[14'h0408] = 32'hFFFF_12FE | ent(8'h12, 1'b1); // dir 2 noisy bits
    mem[14'h049C] = ent(8'h5D, 1'b1);            // frame 0x12 leaf 7

    // R1 R2 R4 R6: basic success
    run_walk({4'd3, 4'd5, 6'h2A}, 14'h0400, 0, 0, 1'b0, 1'b0, "R6");
    // R3: directory invalid, single read
    run_walk({4'd9, 4'd1, 6'h00}, 14'h0400, 0, 1, 1'b0, 1'b0, "R3");
    // R5: leaf invalid
    run_walk({4'd3, 4'd6, 6'h11}, 14'h0400, 1, 2, 1'b0, 1'b0, "R5");
    // R7 R11: stalls with stray responses
    run_walk({4'd3, 4'd5, 6'h01}, 14'h0400, 3, 4, 1'b1, 1'b0, "R11");
    // R9: starts while busy and in the pulse cycle
    run_walk({4'd15, 4'd15, 6'h3F}, 14'h0400, 2, 1, 1'b0, 1'b1, "R9");
    // R2: base wrap
    run_walk({4'd15, 4'd0, 6'h05}, 14'h3FF0, 0, 0, 1'b0, 1'b0, "R2");
    // R1: dir 0 leaf 0
    run_walk({4'd0, 4'd0, 6'h3C}, 14'h0400, 1, 0, 1'b1, 1'b0, "R1");
    // R6: noise bits in directory entry have no effect
    run_walk({4'd2, 4'd7, 6'h15}, 14'h0400, 0, 3, 1'b0, 1'b0, "R6");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule